// File: doc/BRIEF.md
# L2 Fill Return and Writeback Sequencer

This block sits on the return side of a memory-side L2 slice. Responses from the DRAM model land in two small return queues, one for read data and one for write acknowledgements. One item at a time is taken into service. Outstanding requests parked in the external miss-status chain are replayed before any new return is popped. A read item produces a reply toward the interconnect. It then fills the cache when the external probe reports the line absent. If that fill displaces a dirty victim, a writeback is queued.

A writeback that cannot enter the writeback queue is parked in a register and retried every cycle. While it waits, the item that caused it stays in service and nothing else is taken. Write acknowledgements are retired without touching the cache. On the outgoing side, the block chooses between the writeback queue and the external miss queue for the single DRAM request slot.

The cache array, the miss-status storage and the DRAM model are outside the block. The block reaches each of them through plain combinational request/response signals.

Top module: `l2_fill_seq`

## Requirements
- R1: While reset is asserted and right after it, dram_rsp_ready is 1, and dram_req_valid, reply_valid, retire_valid, mshr_pop and mshr_notify are all 0.
- R2: When no item is in service and mshr_chain_valid is 1, the chain head is taken (mshr_pop) and no return queue is popped in that cycle.
- R3: When both return queues hold entries, the read-data queue (responses with dram_rsp_write = 0) is served before the write-acknowledge queue (dram_rsp_write = 1).
- R4: Popping a return raises mshr_notify with its address. In the next cycle, if mshr_chain_valid is 1, the chain head replaces the popped item and the popped item produces no reply of its own.
- R5: A read item raises reply_valid only in a cycle where reply_full is 0. A stalled item keeps waiting, is replied exactly once, and replies leave in service order.
- R6: A read item raises cache_fill, in its reply cycle, only when cache_present is 0, and never more than once.
- R7: A fill with cache_evict_dirty = 1 queues a writeback of cache_evict_addr. If the writeback queue is full, the writeback is retried each cycle, and the item, together with every later return, waits until the writeback is accepted.
- R8: A write acknowledgement raises retire_valid with its tag. It causes neither a reply nor a fill.
- R9: No DRAM request is issued while dram_sched_full is 1. Otherwise a queued writeback (dram_req_wb = 1, tag 0) is issued ahead of the miss queue head, and missq_pop is raised only when the miss head is issued.
- R10: dram_rsp_ready is 0 whenever either return queue is full.
- R11: The all-ones address marks "no writeback pending" and cannot be used as a victim address. A pending writeback always belongs to the item in service, and each eviction is issued to DRAM exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dram_rsp_valid | input | 1 | DRAM response offered |
| dram_rsp_write | input | 1 | 1 = write acknowledgement, 0 = read data |
| dram_rsp_addr | input | AW | Line address of the response |
| dram_rsp_tag | input | TW | Request tag of the response |
| dram_rsp_ready | output | 1 | Both return queues have room |
| mshr_chain_valid | input | 1 | Active miss chain has a waiting request |
| mshr_chain_addr | input | AW | Address of the chain head |
| mshr_chain_tag | input | TW | Tag of the chain head |
| mshr_pop | output | 1 | Chain head taken this cycle |
| mshr_notify | output | 1 | A DRAM return was popped this cycle |
| mshr_notify_addr | output | AW | Address of the popped return |
| reply_full | input | 1 | Reply queue toward the interconnect is full |
| reply_valid | output | 1 | Push reply this cycle |
| reply_addr | output | AW | Reply address |
| reply_tag | output | TW | Reply tag |
| cache_addr | output | AW | Probe / fill address (item in service) |
| cache_present | input | 1 | Probe result: line already present |
| cache_fill | output | 1 | Fill the line this cycle |
| cache_evict_dirty | input | 1 | The fill displaces a dirty line |
| cache_evict_addr | input | AW | Address of the displaced line |
| retire_valid | output | 1 | Write acknowledgement retired this cycle |
| retire_addr | output | AW | Address of the retired write |
| retire_tag | output | TW | Tag of the retired write |
| missq_valid | input | 1 | Miss queue head present |
| missq_write | input | 1 | Miss queue head is a write |
| missq_addr | input | AW | Miss queue head address |
| missq_tag | input | TW | Miss queue head tag |
| missq_pop | output | 1 | Miss queue head issued this cycle |
| dram_sched_full | input | 1 | DRAM scheduler cannot accept a request |
| dram_req_valid | output | 1 | DRAM request issued this cycle |
| dram_req_write | output | 1 | Request is a write |
| dram_req_wb | output | 1 | Request is an eviction writeback |
| dram_req_addr | output | AW | Request address |
| dram_req_tag | output | TW | Request tag (0 for writebacks) |

## Verification
The return path is first driven with directed scripts. One mixes a stalled read, a queued write acknowledgement and a queued read, which separates queue ordering from arrival order. Another attaches a two-entry chain to a returning address, which shows whether the popped item is replaced or wrongly replied. A third pre-arms a chain while a read is queued, which exposes whether replays really win over new returns. A dirty-eviction burst against a blocked DRAM scheduler fills the writeback queue and parks one writeback. This tells retry-and-block behaviour apart from dropped or duplicated writebacks, and it also shows where misses slot in once the scheduler opens. Seeded random reads with random reply back-pressure and address-dependent probe hits check reply order and fill count. Random miss-queue traffic against a random scheduler-full signal checks the issue rule cycle by cycle.

// File: rtl/l2_fill_seq.sv
module l2_fill_seq #(
  parameter int AW        = 16,
  parameter int TW        = 4,
  parameter int RQ_DEPTH  = 4,
  parameter int WBQ_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dram_rsp_valid,
  input  logic          dram_rsp_write,
  input  logic [AW-1:0] dram_rsp_addr,
  input  logic [TW-1:0] dram_rsp_tag,
  output logic          dram_rsp_ready,
  input  logic          mshr_chain_valid,
  input  logic [AW-1:0] mshr_chain_addr,
  input  logic [TW-1:0] mshr_chain_tag,
  output logic          mshr_pop,
  output logic          mshr_notify,
  output logic [AW-1:0] mshr_notify_addr,
  input  logic          reply_full,
  output logic          reply_valid,
  output logic [AW-1:0] reply_addr,
  output logic [TW-1:0] reply_tag,
  output logic [AW-1:0] cache_addr,
  input  logic          cache_present,
  output logic          cache_fill,
  input  logic          cache_evict_dirty,
  input  logic [AW-1:0] cache_evict_addr,
  output logic          retire_valid,
  output logic [AW-1:0] retire_addr,
  output logic [TW-1:0] retire_tag,
  input  logic          missq_valid,
  input  logic          missq_write,
  input  logic [AW-1:0] missq_addr,
  input  logic [TW-1:0] missq_tag,
  output logic          missq_pop,
  input  logic          dram_sched_full,
  output logic          dram_req_valid,
  output logic          dram_req_write,
  output logic          dram_req_wb,
  output logic [AW-1:0] dram_req_addr,
  output logic [TW-1:0] dram_req_tag
);

  localparam int EW  = AW + TW;
  localparam int RPW = $clog2(RQ_DEPTH);
  localparam int WPW = $clog2(WBQ_DEPTH);
  localparam logic [AW-1:0] NO_WB = '1;

  typedef enum logic [1:0] {S_IDLE, S_NEW, S_SERV} st_t;

  st_t           st;
  logic          it_wr;
  logic [AW-1:0] it_addr;
  logic [TW-1:0] it_tag;
  logic [AW-1:0] wb_addr;

  logic [1:0]    rq_push, rq_pop, rq_empty, rq_full;
  logic [EW-1:0] rq_head [2];

  // return queues: index 0 read data, index 1 write acknowledgements
  for (genvar q = 0; q < 2; q++) begin : g_rq
    logic [EW-1:0]  mem [RQ_DEPTH];
    logic [RPW-1:0] wp, rp;
    logic [RPW:0]   cnt;

    assign rq_empty[q] = (cnt == '0);
    assign rq_full[q]  = (cnt == (RPW+1)'(RQ_DEPTH));
    assign rq_head[q]  = mem[rp];
    assign rq_push[q]  = dram_rsp_valid && dram_rsp_ready && (dram_rsp_write == (q == 1));

    always_ff @(posedge clk)
      if (rq_push[q]) mem[wp] <= {dram_rsp_addr, dram_rsp_tag};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (rq_push[q]) wp <= (wp == RPW'(RQ_DEPTH-1)) ? '0 : wp + 1'b1;
        if (rq_pop[q])  rp <= (rp == RPW'(RQ_DEPTH-1)) ? '0 : rp + 1'b1;
        case ({rq_push[q], rq_pop[q]})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: ;
        endcase
      end

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (RPW+1)'(RQ_DEPTH));
  end

  assign dram_rsp_ready = ~|rq_full;

  // writeback queue
  logic [AW-1:0]  wbq_mem [WBQ_DEPTH];
  logic [WPW-1:0] wbq_wp, wbq_rp;
  logic [WPW:0]   wbq_cnt;
  logic           wbq_push, wbq_pop, wbq_empty, wbq_full;
  logic [AW-1:0]  wbq_in, wbq_head;

  assign wbq_empty = (wbq_cnt == '0);
  assign wbq_full  = (wbq_cnt == (WPW+1)'(WBQ_DEPTH));
  assign wbq_head  = wbq_mem[wbq_rp];

  always_ff @(posedge clk)
    if (wbq_push) wbq_mem[wbq_wp] <= wbq_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wbq_wp  <= '0;
      wbq_rp  <= '0;
      wbq_cnt <= '0;
    end else begin
      if (wbq_push) wbq_wp <= (wbq_wp == WPW'(WBQ_DEPTH-1)) ? '0 : wbq_wp + 1'b1;
      if (wbq_pop)  wbq_rp <= (wbq_rp == WPW'(WBQ_DEPTH-1)) ? '0 : wbq_rp + 1'b1;
      case ({wbq_push, wbq_pop})
        2'b10:   wbq_cnt <= wbq_cnt + 1'b1;
        2'b01:   wbq_cnt <= wbq_cnt - 1'b1;
        default: ;
      endcase
    end

  // selection of the next item
  logic          take_chain;
  logic [EW-1:0] popped;

  assign take_chain       = (st == S_IDLE || st == S_NEW) && mshr_chain_valid;
  assign mshr_pop         = take_chain;
  assign rq_pop[0]        = (st == S_IDLE) && !mshr_chain_valid && !rq_empty[0];
  assign rq_pop[1]        = (st == S_IDLE) && !mshr_chain_valid && rq_empty[0] && !rq_empty[1];
  assign mshr_notify      = |rq_pop;
  assign popped           = rq_pop[0] ? rq_head[0] : rq_head[1];
  assign mshr_notify_addr = popped[EW-1:TW];

  // service of the held item
  logic wb_pend, serv_rd, fresh, evict, done;

  assign wb_pend      = (wb_addr != NO_WB);
  assign serv_rd      = (st == S_SERV) && !it_wr;
  assign fresh        = serv_rd && !wb_pend;
  assign reply_valid  = fresh && !reply_full;
  assign cache_fill   = reply_valid && !cache_present;
  assign evict        = cache_fill && cache_evict_dirty;
  assign wbq_push     = (evict || (serv_rd && wb_pend)) && !wbq_full;
  assign wbq_in       = wb_pend ? wb_addr : cache_evict_addr;
  assign retire_valid = (st == S_SERV) && it_wr;
  assign done         = retire_valid || (reply_valid && !evict) || wbq_push;

  assign reply_addr  = it_addr;
  assign reply_tag   = it_tag;
  assign retire_addr = it_addr;
  assign retire_tag  = it_tag;
  assign cache_addr  = it_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      it_wr   <= 1'b0;
      it_addr <= '0;
      it_tag  <= '0;
      wb_addr <= NO_WB;
    end else begin
      case (st)
        S_IDLE:
          if (take_chain) begin
            it_wr   <= 1'b0;
            it_addr <= mshr_chain_addr;
            it_tag  <= mshr_chain_tag;
            st      <= S_SERV;
          end else if (mshr_notify) begin
            it_wr   <= rq_pop[1];
            it_addr <= popped[EW-1:TW];
            it_tag  <= popped[TW-1:0];
            st      <= S_NEW;
          end
        S_NEW: begin
          if (take_chain) begin
            it_wr   <= 1'b0;
            it_addr <= mshr_chain_addr;
            it_tag  <= mshr_chain_tag;
          end
          st <= S_SERV;
        end
        default:
          if (done) st <= S_IDLE;
      endcase
      if (evict && wbq_full) wb_addr <= cache_evict_addr;
      else if (wbq_push)     wb_addr <= NO_WB;
    end

  // outgoing DRAM arbitration
  logic issue_wb;

  assign issue_wb       = !wbq_empty && !dram_sched_full;
  assign wbq_pop        = issue_wb;
  assign missq_pop      = wbq_empty && missq_valid && !dram_sched_full;
  assign dram_req_valid = issue_wb || missq_pop;
  assign dram_req_wb    = issue_wb;
  assign dram_req_write = issue_wb || missq_write;
  assign dram_req_addr  = issue_wb ? wbq_head : missq_addr;
  assign dram_req_tag   = issue_wb ? '0 : missq_tag;

  a_r11_pend_owned: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pend |-> (st == S_SERV && !it_wr));

  a_r2_chain_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && mshr_chain_valid) |-> !mshr_notify);

  a_r4_notify_then_new: assert property (@(posedge clk) disable iff (!rst_n)
    mshr_notify |=> (st == S_NEW));

  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && reply_full) |=> (st == S_SERV && $stable(it_tag) && $stable(it_addr)));

  a_r7_retry_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_pend && wbq_full) |=> (wb_pend && $stable(wb_addr)));

  a_r7_wbq_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wbq_cnt <= (WPW+1)'(WBQ_DEPTH));

  a_r9_wb_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_req_valid && !dram_req_wb) |-> wbq_empty);

  a_r9_sched_block: assert property (@(posedge clk) disable iff (!rst_n)
    dram_sched_full |-> !dram_req_valid);

endmodule

// File: tb/test_l2_fill_seq.sv
module test_l2_fill_seq;
  localparam int AW = 16;
  localparam int TW = 4;
  localparam int K_REPLY = 1, K_RETIRE = 2, K_POP = 3, K_NOTIFY = 4,
                 K_FILL = 5, K_WB = 6, K_MISS = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic dram_rsp_valid = 0, dram_rsp_write = 0;
  logic [AW-1:0] dram_rsp_addr = '0;
  logic [TW-1:0] dram_rsp_tag = '0;
  logic mshr_chain_valid = 0;
  logic [AW-1:0] mshr_chain_addr = '0;
  logic [TW-1:0] mshr_chain_tag = '0;
  logic reply_full = 0;
  logic cache_evict_dirty = 0;
  logic missq_valid = 0, missq_write = 0;
  logic [AW-1:0] missq_addr = '0;
  logic [TW-1:0] missq_tag = '0;
  logic dram_sched_full = 0;
  logic force_present = 0, rand_present = 0, rf_on = 0;

  wire dram_rsp_ready, mshr_pop, mshr_notify, reply_valid, cache_fill, retire_valid;
  wire missq_pop, dram_req_valid, dram_req_write, dram_req_wb, cache_present;
  wire [AW-1:0] mshr_notify_addr, reply_addr, cache_addr, retire_addr, dram_req_addr, cache_evict_addr;
  wire [TW-1:0] reply_tag, retire_tag, dram_req_tag;

  assign cache_present    = force_present | (rand_present & cache_addr[0]);
  assign cache_evict_addr = cache_addr ^ 16'h8000;

  l2_fill_seq #(.AW(AW), .TW(TW), .RQ_DEPTH(4), .WBQ_DEPTH(2)) i_l2_fill_seq (
    .clk(clk), .rst_n(rst_n),
    .dram_rsp_valid(dram_rsp_valid), .dram_rsp_write(dram_rsp_write),
    .dram_rsp_addr(dram_rsp_addr), .dram_rsp_tag(dram_rsp_tag), .dram_rsp_ready(dram_rsp_ready),
    .mshr_chain_valid(mshr_chain_valid), .mshr_chain_addr(mshr_chain_addr),
    .mshr_chain_tag(mshr_chain_tag), .mshr_pop(mshr_pop),
    .mshr_notify(mshr_notify), .mshr_notify_addr(mshr_notify_addr),
    .reply_full(reply_full), .reply_valid(reply_valid), .reply_addr(reply_addr), .reply_tag(reply_tag),
    .cache_addr(cache_addr), .cache_present(cache_present), .cache_fill(cache_fill),
    .cache_evict_dirty(cache_evict_dirty), .cache_evict_addr(cache_evict_addr),
    .retire_valid(retire_valid), .retire_addr(retire_addr), .retire_tag(retire_tag),
    .missq_valid(missq_valid), .missq_write(missq_write), .missq_addr(missq_addr),
    .missq_tag(missq_tag), .missq_pop(missq_pop),
    .dram_sched_full(dram_sched_full), .dram_req_valid(dram_req_valid),
    .dram_req_write(dram_req_write), .dram_req_wb(dram_req_wb),
    .dram_req_addr(dram_req_addr), .dram_req_tag(dram_req_tag)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // event log
  int ev_k [1024];
  int ev_v [1024];
  int n_ev = 0;
  task automatic lg(input int k, input int v);
    if (n_ev < 1024) begin ev_k[n_ev] = k; ev_v[n_ev] = v; n_ev++; end
  endtask
  function automatic int find(input int k, input int v);
    for (int i = 0; i < n_ev; i++) if (ev_k[i] == k && ev_v[i] == v) return i;
    return -1;
  endfunction
  function automatic int count(input int k);
    int c = 0;
    for (int i = 0; i < n_ev; i++) if (ev_k[i] == k) c++;
    return c;
  endfunction
  function automatic int count_kv(input int k, input int v);
    int c = 0;
    for (int i = 0; i < n_ev; i++) if (ev_k[i] == k && ev_v[i] == v) c++;
    return c;
  endfunction
  function automatic int nth_wb(input int n);
    int c = 0;
    for (int i = 0; i < n_ev; i++)
      if (ev_k[i] == K_WB || ev_k[i] == K_MISS) begin
        if (c == n) return (ev_k[i] == K_WB) ? ev_v[i] : -1;
        c++;
      end
    return -2;
  endfunction
  function automatic int nth_reply(input int n);
    int c = 0;
    for (int i = 0; i < n_ev; i++)
      if (ev_k[i] == K_REPLY) begin
        if (c == n) return ev_v[i];
        c++;
      end
    return -1;
  endfunction
  function automatic bit exp_fill(input logic [AW-1:0] a);
    return !a[0];
  endfunction
  function automatic bit exp_issue(input bit v, input bit full);
    return v && !full;
  endfunction

  // miss-status chain model and monitor
  logic [AW-1:0] ch_key = '0;
  logic [TW-1:0] ch_tags [4];
  bit ch_armed = 0, ch_active = 0;
  int ch_len = 0, ch_idx = 0;

  always begin
    @(negedge clk);
    #1;
    mshr_chain_valid = ch_active && ch_idx < ch_len;
    mshr_chain_addr  = ch_key;
    mshr_chain_tag   = (ch_idx < 4) ? ch_tags[ch_idx] : '0;
    #7;
    if (rst_n) begin
      if (mshr_pop)       lg(K_POP, int'(mshr_chain_tag));
      if (mshr_notify)    lg(K_NOTIFY, int'(mshr_notify_addr));
      if (reply_valid)    lg(K_REPLY, int'(reply_tag));
      if (cache_fill)     lg(K_FILL, int'(cache_addr));
      if (retire_valid)   lg(K_RETIRE, int'(retire_tag));
      if (dram_req_valid) lg(dram_req_wb ? K_WB : K_MISS,
                             dram_req_wb ? int'(dram_req_addr) : int'(dram_req_tag));
      if (mshr_pop) begin
        ch_idx++;
        if (ch_idx >= ch_len) ch_active = 0;
      end
      if (mshr_notify && ch_armed && mshr_notify_addr == ch_key) begin
        ch_active = 1;
        ch_armed  = 0;
      end
    end
  end

  always begin
    @(negedge clk);
    if (rf_on) reply_full = (($urandom % 10) < 3);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic w, input logic [AW-1:0] a, input logic [TW-1:0] t);
    @(negedge clk);
    while (!dram_rsp_ready) @(negedge clk);
    dram_rsp_valid = 1; dram_rsp_write = w; dram_rsp_addr = a; dram_rsp_tag = t;
    @(negedge clk);
    dram_rsp_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int a, b, c;
    logic [TW-1:0] exp_tags [40];
    int exp_fills;
    void'($urandom(32'h5EED1234));

    // R1 reset state
    cyc(2);
    #8;
    chk(dram_rsp_ready == 1, "R1 ready in reset", dram_rsp_ready, 1);
    chk(!dram_req_valid && !reply_valid && !retire_valid && !mshr_pop && !mshr_notify,
        "R1 outputs idle in reset", int'(dram_req_valid | reply_valid | retire_valid), 0);
    @(negedge clk); rst_n = 1;
    #8;
    chk(dram_rsp_ready == 1 && !dram_req_valid && !reply_valid, "R1 after reset",
        int'(dram_req_valid | reply_valid), 0);

    // ordering of return queues, write ack retire
    force_present = 1; reply_full = 1; dram_sched_full = 1;
    @(negedge clk); n_ev = 0;
    push(0, 16'h0010, 4'd1);
    push(1, 16'h0020, 4'd2);
    push(0, 16'h0030, 4'd3);
    cyc(3);
    reply_full = 0;
    cyc(12);
    a = find(K_REPLY, 3); b = find(K_RETIRE, 2);
    chk(a >= 0 && b >= 0 && a < b, "R3 read queue before write queue", a, b);
    chk(find(K_NOTIFY, 16'h10) >= 0 && find(K_NOTIFY, 16'h10) < find(K_REPLY, 1),
        "R4 notify precedes reply", find(K_NOTIFY, 16'h10), find(K_REPLY, 1));
    chk(find(K_REPLY, 2) == -1 && b >= 0, "R8 write ack retired without reply", find(K_REPLY, 2), -1);
    chk(count(K_FILL) == 0, "R6 no fill when present", count(K_FILL), 0);

    // chain replaces the popped item
    ch_key = 16'h0040; ch_tags[0] = 4'd5; ch_tags[1] = 4'd6; ch_len = 2; ch_idx = 0; ch_armed = 1;
    n_ev = 0;
    push(0, 16'h0040, 4'd4);
    cyc(10);
    chk(find(K_REPLY, 4) == -1, "R4 popped item replaced by chain head", find(K_REPLY, 4), -1);
    a = find(K_REPLY, 5); b = find(K_REPLY, 6);
    chk(a >= 0 && b > a, "R4 chain entries replied in order", a, b);
    chk(count(K_POP) == 2, "R4 chain pops", count(K_POP), 2);

    // chain wins over queued return
    reply_full = 1;
    @(negedge clk); n_ev = 0;
    push(0, 16'h0070, 4'd9);
    push(0, 16'h0072, 4'd8);
    @(negedge clk);
    ch_key = 16'h0099; ch_tags[0] = 4'd7; ch_len = 1; ch_idx = 0; ch_active = 1;
    cyc(2);
    chk(find(K_REPLY, 9) == -1, "R5 no reply while reply_full", find(K_REPLY, 9), -1);
    reply_full = 0;
    cyc(10);
    a = find(K_POP, 7); b = find(K_NOTIFY, 16'h72);
    chk(a >= 0 && b > a, "R2 chain taken before queued return", a, b);
    chk(find(K_REPLY, 7) < find(K_REPLY, 8), "R2 chain reply first", find(K_REPLY, 7), find(K_REPLY, 8));
    chk(count_kv(K_REPLY, 9) == 1, "R5 stalled item replied once", count_kv(K_REPLY, 9), 1);

    // dirty eviction, blocked writeback, DRAM arbitration
    force_present = 0; cache_evict_dirty = 1; dram_sched_full = 1;
    @(negedge clk); n_ev = 0;
    push(0, 16'h0060, 4'd10);
    push(0, 16'h0061, 4'd11);
    push(0, 16'h0062, 4'd12);
    cyc(4);
    push(0, 16'h0063, 4'd13);
    cyc(8);
    chk(count(K_FILL) == 3, "R6 one fill per absent line", count(K_FILL), 3);
    chk(count(K_REPLY) == 3, "R7 pending writeback does not repeat reply", count(K_REPLY), 3);
    chk(find(K_REPLY, 13) == -1, "R7 pending writeback blocks next item", find(K_REPLY, 13), -1);
    chk(count(K_WB) + count(K_MISS) == 0, "R9 nothing issued while scheduler full",
        count(K_WB) + count(K_MISS), 0);
    @(negedge clk);
    missq_valid = 1; missq_tag = 4'd14; missq_addr = 16'h0077; dram_sched_full = 0;
    cyc(10);
    missq_valid = 0;
    cyc(4);
    chk(nth_wb(0) == 16'h8060, "R9 writeback issued first", nth_wb(0), 16'h8060);
    chk(nth_wb(1) == 16'h8061, "R9 second writeback before miss", nth_wb(1), 16'h8061);
    chk(nth_wb(2) == 16'h8062, "R7 retried writeback address", nth_wb(2), 16'h8062);
    a = find(K_WB, 16'h8062); b = find(K_REPLY, 13);
    chk(a >= 0 && b > a, "R7 next item after writeback accepted", a, b);
    chk(count(K_MISS) > 0, "R9 miss issued once writebacks drain", count(K_MISS), 1);
    chk(count(K_WB) == 4, "R11 each eviction issued exactly once", count(K_WB), 4);

    // return queue full
    force_present = 1; cache_evict_dirty = 0; reply_full = 1;
    @(negedge clk); n_ev = 0;
    for (int i = 0; i < 5; i++) push(0, 16'h0100 + 16'(i), 4'(i));
    chk(dram_rsp_ready == 0, "R10 ready low with full read queue", dram_rsp_ready, 0);
    reply_full = 0;
    cyc(30);
    chk(dram_rsp_ready == 1, "R10 ready back after drain", dram_rsp_ready, 1);
    for (int i = 0; i < 5; i++)
      chk(nth_reply(i) == i, "R5 replies in service order", nth_reply(i), i);

    // random reads with back-pressure
    force_present = 0; rand_present = 1;
    @(negedge clk); n_ev = 0; exp_fills = 0; rf_on = 1;
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] ad;
      ad = 16'($urandom % 16'h7000) + 16'h0200;
      exp_tags[i] = 4'(i);
      if (exp_fill(ad)) exp_fills++;
      push(0, ad, 4'(i));
    end
    rf_on = 0;
    @(negedge clk); reply_full = 0;
    cyc(40);
    for (int i = 0; i < 40; i++)
      chk(nth_reply(i) == int'(exp_tags[i]), "R5 random reply order", nth_reply(i), int'(exp_tags[i]));
    chk(count(K_FILL) == exp_fills, "R6 random fill count", count(K_FILL), exp_fills);

    // random miss traffic against scheduler full
    for (int i = 0; i < 60; i++) begin
      bit v, f;
      @(negedge clk);
      v = $urandom % 2; f = ($urandom % 3) == 0;
      missq_valid = v; dram_sched_full = f; missq_tag = 4'($urandom); missq_write = $urandom % 2;
      #8;
      c = exp_issue(v, f);
      chk(dram_req_valid == c && missq_pop == c && (!c || (!dram_req_wb && dram_req_tag == missq_tag)),
          "R9 miss issue rule", int'(dram_req_valid), c);
    end
    @(negedge clk); missq_valid = 0; dram_sched_full = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule